// File: doc/BRIEF.md
# Circular Trace Capture Buffer

This block is an on-chip trace sink. While capture is switched on, it writes each valid 32-bit trace word from an incoming stream into a small circular RAM. Once the write position passes the last entry it returns to entry zero, so the RAM always holds the newest words. A debugger switches capture off and then drains the RAM through a 32-bit register port. Each read of the data register returns one word and moves the read position forward. Both positions are plain word indices that software may reload at any time, so a dump can begin at the oldest word. A wrap flag says whether the oldest word sits at the write position or at index zero.

All register writes are blocked until a fixed unlock key has been written to the key register. Any other value written there blocks them again. Words are always stored raw, with no framing. The formatter control register only holds the value written to it.

The register port takes word offsets. Reads return data combinationally in the same cycle as the address. Writes and pointer moves take effect at the next rising clock edge.

Top module: `trace_ring_buffer`

## Requirements
- R1: After reset the block is locked, capture is off, both pointers are 0 and the wrap flag is clear. The lock status register (word 0x3ED) reads 1 and the control register (word 0x008) reads 0.
- R2: Writing 0xC5ACCE55 to the key register (word 0x3EC) unlocks the block, and lock status bit 0 then reads 0. Writing any other value there locks the block again, and bit 0 reads 1.
- R3: While the block is locked, writes to every register other than the key register are ignored.
- R4: While control bit 0 (capture on) is 1, each cycle with `tr_valid` high stores `tr_word` at the write pointer (word 0x006), and the write pointer then advances by one.
- R5: When the write pointer advances from DEPTH-1 it goes to 0 and sets the wrap flag, which is status bit 0 at word 0x000. A software load of the write pointer clears the flag. If a load and a wrap fall in the same cycle, the flag is cleared.
- R6: While capture is off, reading the data register (word 0x004) returns the RAM word at the read pointer (word 0x005), and the read pointer advances by one, going from DEPTH-1 to 0. While capture is on, the same read returns 0 and the read pointer does not move.
- R7: When unlocked, writing the read or write pointer loads the written value modulo DEPTH. A load wins over an advance in the same cycle. A trace word arriving in that cycle is still stored at the old write position.
- R8: The depth register (word 0x001) reads DEPTH. Formatter status bit 1 (word 0x0C0) reads 1 exactly when capture is off.
- R9: With capture off and the block unlocked, writing the write-data register (word 0x009) stores the value at the write pointer and advances it. This write is ignored while capture is on.
- R10: The trigger count register (word 0x007, 32 bits) and formatter control register (word 0x0C1, bits 1:0) read back what was written. Trace words are stored raw regardless of formatter control.
- R11: While capture is off, `tr_valid` has no effect: the write pointer and the RAM contents are unchanged.
- R12: Reads of unmapped offsets and of the write-data register return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tr_valid | input | 1 | Trace word valid |
| tr_word | input | 32 | Trace word |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (only the data register has a side effect) |
| reg_addr | input | 10 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |

## Verification
A wrong pointer shows up on the very next read of the pointer register. It also shows up within one read of the data register, as a word taken from the wrong entry. A lost or spurious wrap changes the wrap flag at once. It also shifts every word of a full drain that starts at the write pointer, so a whole ring dump after an overflow exposes it. A lock that does not hold shows up as a control or pointer value that changed after a blocked write, and this is visible on the next readback.

// File: rtl/trb_pkg.sv
// trb_pkg: register word offsets, unlock key and the decoded write-strobe type
// shared by the trace ring buffer modules. Assumes a 10-bit word-offset port.
package trb_pkg;
    localparam int REG_AW = 10;
    localparam int DW     = 32;

    localparam logic [REG_AW-1:0] OFS_STATUS = 10'h000;
    localparam logic [REG_AW-1:0] OFS_DEPTH  = 10'h001;
    localparam logic [REG_AW-1:0] OFS_RDATA  = 10'h004;
    localparam logic [REG_AW-1:0] OFS_RPTR   = 10'h005;
    localparam logic [REG_AW-1:0] OFS_WPTR   = 10'h006;
    localparam logic [REG_AW-1:0] OFS_TRIG   = 10'h007;
    localparam logic [REG_AW-1:0] OFS_CTRL   = 10'h008;
    localparam logic [REG_AW-1:0] OFS_WDATA  = 10'h009;
    localparam logic [REG_AW-1:0] OFS_FSTAT  = 10'h0C0;
    localparam logic [REG_AW-1:0] OFS_FCTRL  = 10'h0C1;
    localparam logic [REG_AW-1:0] OFS_LOCK   = 10'h3EC;
    localparam logic [REG_AW-1:0] OFS_LSTAT  = 10'h3ED;

    localparam logic [DW-1:0] UNLOCK_KEY = 32'hC5AC_CE55;

    // Decoded, lock-qualified register write strobes
    typedef struct packed {
        logic ctrl;
        logic trig;
        logic fctrl;
        logic rptr;
        logic wptr;
        logic wdata;
    } wr_strobe_t;
endpackage

// File: rtl/trb_lock.sv
// trb_lock: write-guard state. Powers up locked; the unlock key clears the
// lock and any other value written to the key register sets it again.
// Assumes key_wr is a single-cycle strobe qualified by the key offset.
module trb_lock
    import trb_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          key_wr,
    input  logic [DW-1:0] key_val,
    output logic          locked
);
    // Track lock state from key register writes
    always_ff @(posedge clk) begin
        if (!rst_n)      locked <= 1'b1;
        else if (key_wr) locked <= (key_val != UNLOCK_KEY);
    end
endmodule

// File: rtl/trb_ptr.sv
// trb_ptr: word-index pointer over a ring of DEPTH entries. A load wins over
// a step; a step from DEPTH-1 returns to zero and pulses wrap combinationally.
// Assumes DEPTH is a power of two so a loaded value is taken modulo DEPTH.
module trb_ptr #(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          step,
    output logic [AW-1:0] ptr,
    output logic          wrap
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    // Flag a rollover when stepping off the last entry without a load
    always_comb wrap = step && !load && (ptr == LAST);

    // Hold, load or advance the pointer
    always_ff @(posedge clk) begin
        if (!rst_n)    ptr <= '0;
        else if (load) ptr <= load_val;
        else if (step) ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end
endmodule

// File: rtl/trb_ram.sv
// trb_ram: DEPTH x DW storage with one synchronous write port and one
// asynchronous read port. Contents are not reset.
module trb_ram #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    // Store one word per write strobe
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Present the word at the read address
    always_comb rdata = mem[raddr];
endmodule

// File: rtl/trace_ring_buffer.sv
// trace_ring_buffer: circular trace sink. Captures trace words while enabled,
// lets software drain them through an auto-advancing data register while
// disabled, and guards all register writes with a key-based lock.
// Assumes DEPTH is a power of two and reg_addr carries word offsets.
module trace_ring_buffer
    import trb_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tr_valid,
    input  logic [DW-1:0]     tr_word,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata
);
    localparam int AW = $clog2(DEPTH);

    logic          locked_q;
    logic          cap_en_q;
    logic          wrap_q;
    logic [DW-1:0] trig_q;
    logic [1:0]    fctrl_q;
    logic [AW-1:0] wptr, rptr;
    logic          wptr_wrap, rptr_wrap;
    logic          ram_we, cap_wr, sw_wr, rd_pop;
    logic [DW-1:0] ram_wdata, ram_rdata;
    wr_strobe_t    ws;

    trb_lock u_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .key_wr  (reg_wr && reg_addr == OFS_LOCK),
        .key_val (reg_wdata),
        .locked  (locked_q)
    );

    // Decode register writes that the lock permits
    always_comb begin
        ws       = '0;
        if (reg_wr && !locked_q) begin
            ws.ctrl  = (reg_addr == OFS_CTRL);
            ws.trig  = (reg_addr == OFS_TRIG);
            ws.fctrl = (reg_addr == OFS_FCTRL);
            ws.rptr  = (reg_addr == OFS_RPTR);
            ws.wptr  = (reg_addr == OFS_WPTR);
            ws.wdata = (reg_addr == OFS_WDATA);
        end
    end

    // Select the RAM write source: capture when enabled, software when idle
    always_comb begin
        cap_wr    = cap_en_q && tr_valid;
        sw_wr     = !cap_en_q && ws.wdata;
        ram_we    = cap_wr || sw_wr;
        ram_wdata = cap_wr ? tr_word : reg_wdata;
        rd_pop    = reg_rd && (reg_addr == OFS_RDATA) && !cap_en_q;
    end

    trb_ptr #(.DEPTH(DEPTH)) u_wptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ws.wptr),
        .load_val (reg_wdata[AW-1:0]),
        .step     (ram_we),
        .ptr      (wptr),
        .wrap     (wptr_wrap)
    );

    trb_ptr #(.DEPTH(DEPTH)) u_rptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ws.rptr),
        .load_val (reg_wdata[AW-1:0]),
        .step     (rd_pop),
        .ptr      (rptr),
        .wrap     (rptr_wrap)
    );

    trb_ram #(.DEPTH(DEPTH), .WIDTH(DW)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (wptr),
        .wdata (ram_wdata),
        .raddr (rptr),
        .rdata (ram_rdata)
    );

    // Hold the control, trigger and formatter registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_en_q <= 1'b0;
            trig_q   <= '0;
            fctrl_q  <= '0;
        end else begin
            if (ws.ctrl)  cap_en_q <= reg_wdata[0];
            if (ws.trig)  trig_q   <= reg_wdata;
            if (ws.fctrl) fctrl_q  <= reg_wdata[1:0];
        end
    end

    // Track ring rollover; a software pointer load restarts the history
    always_ff @(posedge clk) begin
        if (!rst_n)         wrap_q <= 1'b0;
        else if (ws.wptr)   wrap_q <= 1'b0;
        else if (wptr_wrap) wrap_q <= 1'b1;
    end

    // Return register contents for the addressed word offset
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_STATUS: reg_rdata = {{(DW-1){1'b0}}, wrap_q};
            OFS_DEPTH:  reg_rdata = DW'(DEPTH);
            OFS_RDATA:  reg_rdata = cap_en_q ? '0 : ram_rdata;
            OFS_RPTR:   reg_rdata = DW'(rptr);
            OFS_WPTR:   reg_rdata = DW'(wptr);
            OFS_TRIG:   reg_rdata = trig_q;
            OFS_CTRL:   reg_rdata = {{(DW-1){1'b0}}, cap_en_q};
            OFS_FSTAT:  reg_rdata = {{(DW-2){1'b0}}, !cap_en_q, 1'b0};
            OFS_FCTRL:  reg_rdata = {{(DW-2){1'b0}}, fctrl_q};
            OFS_LSTAT:  reg_rdata = {{(DW-1){1'b0}}, locked_q};
            default:    reg_rdata = '0;
        endcase
    end

    // Read-pointer rollover is not needed outside the pointer itself
    logic unused_rwrap;
    always_comb unused_rwrap = rptr_wrap;
endmodule

// File: rtl/trb_checker.sv
// trb_checker: temporal properties of the trace ring buffer, bound to the top.
// Assumes DEPTH is a power of two so pointer increments wrap in AW bits.
module trb_checker
    import trb_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [REG_AW-1:0] reg_addr,
    input logic [DW-1:0]     reg_wdata,
    input logic              tr_valid,
    input logic              locked,
    input logic              cap_en,
    input logic [AW-1:0]     wptr,
    input logic [AW-1:0]     rptr
);
    p_key_lock_r2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && reg_addr == OFS_LOCK |=> locked == ($past(reg_wdata) != UNLOCK_KEY));

    p_locked_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        locked && !cap_en && reg_wr && !reg_rd && reg_addr != OFS_LOCK
        |=> $stable(cap_en) && $stable(wptr) && $stable(rptr));

    p_capture_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en && tr_valid && !reg_wr |=> wptr == AW'($past(wptr) + 1'b1));

    p_drain_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en && reg_rd && reg_addr == OFS_RDATA && !reg_wr
        |=> rptr == AW'($past(rptr) + 1'b1));

    p_frozen_rptr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en && reg_rd && !reg_wr |=> $stable(rptr));

    p_idle_wptr_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en && !reg_wr |=> $stable(wptr));
endmodule

bind trace_ring_buffer trb_checker #(.DEPTH(DEPTH)) u_trb_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .tr_valid  (tr_valid),
    .locked    (locked_q),
    .cap_en    (cap_en_q),
    .wptr      (wptr),
    .rptr      (rptr)
);

// File: tb/tb_trace_ring_buffer.sv
// tb_trace_ring_buffer: drives one register/trace operation per cycle and
// compares every read against a behavioural model of the requirements.
module tb_trace_ring_buffer;
    localparam int DEPTH = 16;
    localparam logic [31:0] KEY = 32'hC5AC_CE55;
    localparam logic [9:0] A_STATUS = 10'h000, A_DEPTH = 10'h001, A_RDATA = 10'h004,
        A_RPTR = 10'h005, A_WPTR = 10'h006, A_TRIG = 10'h007, A_CTRL = 10'h008,
        A_WDATA = 10'h009, A_FSTAT = 10'h0C0, A_FCTRL = 10'h0C1, A_LOCK = 10'h3EC,
        A_LSTAT = 10'h3ED, A_NONE = 10'h155;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        tr_valid = 0;
    logic [31:0] tr_word = '0;
    logic        reg_wr = 0, reg_rd = 0;
    logic [9:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int checks = 0, errors = 0;
    bit done = 0;

    // model state
    logic [31:0] m_mem [DEPTH];
    int  m_wp = 0, m_rp = 0;
    bit  m_en = 0, m_locked = 1, m_wrap = 0;
    logic [31:0] m_trig = '0;
    logic [1:0]  m_fctrl = '0;

    trace_ring_buffer #(.DEPTH(DEPTH)) dut (.*);

    always #2 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] m_read(input logic [9:0] a);
        case (a)
            A_STATUS: return {31'b0, m_wrap};
            A_DEPTH:  return DEPTH;
            A_RDATA:  return m_en ? 32'h0 : m_mem[m_rp];
            A_RPTR:   return m_rp;
            A_WPTR:   return m_wp;
            A_TRIG:   return m_trig;
            A_CTRL:   return {31'b0, m_en};
            A_FSTAT:  return {30'b0, !m_en, 1'b0};
            A_FCTRL:  return {30'b0, m_fctrl};
            A_LSTAT:  return {31'b0, m_locked};
            default:  return 32'h0;
        endcase
    endfunction

    // one cycle: drive, check read value, clock, update model
    task automatic op(input string tag, input bit w, input bit r, input logic [9:0] a,
                      input logic [31:0] d, input bit tv, input logic [31:0] tw);
        bit cap, sw;
        @(negedge clk);
        reg_wr = w; reg_rd = r; reg_addr = a; reg_wdata = d; tr_valid = tv; tr_word = tw;
        #1;
        if (r) chk(tag, reg_rdata, m_read(a));
        @(posedge clk);
        cap = m_en && tv;
        sw  = !m_en && !m_locked && w && a == A_WDATA;
        if (cap) m_mem[m_wp] = tw;
        else if (sw) m_mem[m_wp] = d;
        if (!m_locked && w && a == A_RPTR) m_rp = d % DEPTH;
        else if (r && a == A_RDATA && !m_en) m_rp = (m_rp + 1) % DEPTH;
        if (!m_locked && w && a == A_WPTR) begin m_wp = d % DEPTH; m_wrap = 0; end
        else if (cap || sw) begin
            if (m_wp == DEPTH - 1) m_wrap = 1;
            m_wp = (m_wp + 1) % DEPTH;
        end
        if (!m_locked && w) begin
            if (a == A_CTRL)  m_en = d[0];
            if (a == A_TRIG)  m_trig = d;
            if (a == A_FCTRL) m_fctrl = d[1:0];
        end
        if (w && a == A_LOCK) m_locked = (d != KEY);
    endtask

    task automatic wr(input string tag, input logic [9:0] a, input logic [31:0] d);
        op(tag, 1, 0, a, d, 0, 0);
    endtask
    task automatic rd(input string tag, input logic [9:0] a);
        op(tag, 0, 1, a, 0, 0, 0);
    endtask
    task automatic tw(input string tag, input logic [31:0] word);
        op(tag, 0, 0, A_NONE, 0, 1, word);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;

        // R1 reset state; R8 depth and stopped; R12 unmapped
        rd("R1 lock status", A_LSTAT);
        rd("R1 control", A_CTRL);
        rd("R1 wptr", A_WPTR);
        rd("R1 rptr", A_RPTR);
        rd("R1 wrap flag", A_STATUS);
        rd("R8 depth", A_DEPTH);
        rd("R8 stopped", A_FSTAT);
        rd("R12 unmapped", A_NONE);

        // R3 locked writes ignored
        wr("R3", A_CTRL, 1);
        wr("R3", A_WPTR, 5);
        wr("R3", A_TRIG, 32'hDEAD);
        rd("R3 ctrl after locked write", A_CTRL);
        rd("R3 wptr after locked write", A_WPTR);
        rd("R3 trig after locked write", A_TRIG);

        // R2 unlock
        wr("R2", A_LOCK, KEY);
        rd("R2 unlocked status", A_LSTAT);

        // R10 trigger and formatter control
        wr("R10", A_TRIG, 32'h0000_1234);
        wr("R10", A_FCTRL, 32'h3);
        rd("R10 trig readback", A_TRIG);
        rd("R10 fctrl readback", A_FCTRL);
        wr("R10", A_FCTRL, 32'h0);

        // R4 capture
        wr("R4", A_CTRL, 1);
        rd("R8 running", A_FSTAT);
        for (int i = 0; i < 5; i++) tw("R4", 32'hA000_0000 + i);
        rd("R4 wptr after five words", A_WPTR);
        op("R4 gaps", 0, 0, A_NONE, 0, 0, 32'hFFFF_FFFF);
        rd("R6 data while capturing", A_RDATA);
        rd("R6 rptr frozen while capturing", A_RPTR);

        // R5 wrap
        for (int i = 5; i < 18; i++) tw("R5", 32'hA000_0000 + i);
        rd("R5 wptr after wrap", A_WPTR);
        rd("R5 wrap flag set", A_STATUS);

        // R11 trace ignored when idle
        wr("R11", A_CTRL, 0);
        for (int i = 0; i < 3; i++) tw("R11", 32'hBAD0_0000 + i);
        rd("R11 wptr unchanged", A_WPTR);

        // R6 drain whole ring from oldest word
        wr("R6", A_RPTR, m_wp);
        for (int i = 0; i < DEPTH; i++) rd("R6 drain word", A_RDATA);
        rd("R6 rptr after full drain", A_RPTR);

        // R7 modulo load and load-over-step priority
        wr("R7", A_RPTR, 32'h13);
        rd("R7 rptr modulo", A_RPTR);
        wr("R7", A_CTRL, 1);
        op("R7 load with capture", 1, 0, A_WPTR, 32'd15, 1, 32'hC0DE_0001);
        rd("R7 wptr loaded", A_WPTR);
        rd("R5 wrap cleared by load", A_STATUS);
        tw("R5", 32'hC0DE_0002);
        rd("R5 wrap after rollover", A_STATUS);
        wr("R5", A_WPTR, 0);
        rd("R5 wrap cleared again", A_STATUS);

        // R9 software write path, ignored while capturing
        wr("R9", A_WDATA, 32'h5555_0000);
        rd("R9 wptr unchanged while capturing", A_WPTR);
        wr("R9", A_CTRL, 0);
        wr("R9", A_WDATA, 32'h5555_0001);
        wr("R9", A_WDATA, 32'h5555_0002);
        rd("R9 wptr after writes", A_WPTR);
        rd("R12 write-data reads zero", A_WDATA);
        wr("R9", A_RPTR, 0);
        for (int i = 0; i < 3; i++) rd("R9 readback", A_RDATA);

        // R2 relock, R3 ignored again
        wr("R2", A_LOCK, 32'h1234_5678);
        rd("R2 relocked", A_LSTAT);
        wr("R3", A_CTRL, 1);
        wr("R3", A_RPTR, 9);
        rd("R3 ctrl while relocked", A_CTRL);
        rd("R3 rptr while relocked", A_RPTR);

        @(negedge clk);
        reg_wr = 0; reg_rd = 0; tr_valid = 0;
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule